// File: doc/BRIEF.md
# Instruction Error Merge and Halt Controller

This block sits at the retirement point of a small core. In every instruction cycle several independent checkers (address range and alignment, call-stack depth, loop nesting, illegal encoding and others) can each raise an error code. The block merges all of them with a bitwise OR. At the end of the instruction it decides between two strobes: `commit_o`, which lets the instruction's pending architectural writes land, and `abort_o`, which discards every one of them. It produces exactly one of the two for each completed instruction.

When any error is seen, the block halts the core. It latches the merged code into the error-bits register, sets the done flag and clears busy. A clean end-of-program instruction takes the same path and leaves an error-bits value of zero. A start command from the host side clears the error bits and done and sets busy again. The reset input is asserted asynchronously and released synchronously to the clock.

Top module: `err_halt_ctrl`

## Requirements
- R1: Source k occupies bits [k*ERR_W +: ERR_W] of `src_err_i`. When an instruction aborts, `err_bits_o` becomes the bitwise OR of the codes of every source, however many of them are non-zero.
- R2: In a cycle with `insn_end_i`=1, `busy_o`=1 and `stall_i`=0, `abort_o` is 1 if any source code is non-zero and `commit_o` is 1 otherwise. Both are combinational in that cycle.
- R3: `commit_o` and `abort_o` are never high together, and each lasts only the single end-of-instruction cycle.
- R4: While `stall_i`=1, `insn_end_i` and the source codes have no effect: there is no strobe, and busy, done and the error bits do not change.
- R5: On the clock edge that ends an aborted instruction, `busy_o` goes to 0 and `done_o` goes to 1.
- R6: An instruction with `halt_req_i`=1 and no error commits, then halts with `err_bits_o`=0, `done_o`=1 and `busy_o`=0. If it also has an error, it aborts and reports the merged code.
- R7: Once halted (`busy_o`=0), `insn_end_i` produces no strobe and changes no status.
- R8: Bit 7 of a source code, the fatal-register class, appears at bit 7 of `err_bits_o`.
- R9: `err_bits_o` holds its value until a start. `start_i`, when the block is idle, clears the error bits and done and sets busy on the next edge.
- R10: After reset, busy, done and the error bits are 0, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start command; takes effect only while idle |
| insn_end_i | input | 1 | Marks the last cycle of an instruction |
| stall_i | input | 1 | Stall cycle; the end strobe is ignored |
| halt_req_i | input | 1 | The current instruction ends the program |
| src_err_i | input | NUM_SRC*ERR_W | Packed per-source error codes |
| commit_o | output | 1 | Let the pending writes commit |
| abort_o | output | 1 | Discard the pending writes |
| err_bits_o | output | ERR_W | Merged error bits of the halting instruction |
| done_o | output | 1 | Done flag (interrupt state bit 0) |
| busy_o | output | 1 | Busy flag (status bit 0) |

## Verification
The bench builds the block with its defaults: four sources and 8-bit codes. Four sources are enough to raise an error on every source in the same instruction. Codes a full byte wide reach the fatal bit 7, and they let the bench choose codes whose bits overlap or stay disjoint, so that an OR can be told apart from a "first source wins" choice.

// File: rtl/ehc_pkg.sv
package ehc_pkg;
  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_COMMIT = 2'd1,
    OUT_ABORT  = 2'd2
  } outcome_e;
endpackage

// File: rtl/ehc_merge.sv
module ehc_merge #(
  parameter int NUM_SRC = 4,
  parameter int ERR_W   = 8
) (
  input  logic [NUM_SRC*ERR_W-1:0] codes_i,
  output logic [ERR_W-1:0]         merged_o,
  output logic                     any_o
);
  // Running OR chain: one stage per source.
  logic [ERR_W-1:0] acc [NUM_SRC+1];

  assign acc[0] = '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
    assign acc[g+1] = acc[g] | codes_i[g*ERR_W +: ERR_W];
  end

  assign merged_o = acc[NUM_SRC];
  assign any_o    = |acc[NUM_SRC];
endmodule

// File: rtl/ehc_decide.sv
module ehc_decide
  import ehc_pkg::*;
(
  input  logic     busy_i,
  input  logic     insn_end_i,
  input  logic     stall_i,
  input  logic     any_err_i,
  input  logic     halt_req_i,
  output outcome_e outcome_o,
  output logic     stop_o
);
  logic retire;

  assign retire = busy_i && insn_end_i && !stall_i;

  always_comb begin
    outcome_o = OUT_NONE;
    if (retire) begin
      outcome_o = any_err_i ? OUT_ABORT : OUT_COMMIT;
    end
  end

  assign stop_o = (outcome_o == OUT_ABORT) || ((outcome_o == OUT_COMMIT) && halt_req_i);
endmodule

// File: rtl/ehc_status.sv
module ehc_status #(
  parameter int ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [ERR_W-1:0] merged_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_bits_o
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             start_eff;
  logic             upd_en;

  assign start_eff = start_i && !busy_q;
  assign upd_en    = start_eff || stop_i;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    err_d  = err_q;
    if (start_eff) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      err_d  = '0;
    end else if (stop_i) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      err_d  = merged_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_bits_o = err_q;
endmodule

// File: rtl/err_halt_ctrl.sv
module err_halt_ctrl
  import ehc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ERR_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     insn_end_i,
  input  logic                     stall_i,
  input  logic                     halt_req_i,
  input  logic [NUM_SRC*ERR_W-1:0] src_err_i,
  output logic                     commit_o,
  output logic                     abort_o,
  output logic [ERR_W-1:0]         err_bits_o,
  output logic                     done_o,
  output logic                     busy_o
);
  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  logic [ERR_W-1:0] merged;
  logic             any_err;
  outcome_e         outcome;
  logic             stop;

  ehc_merge #(.NUM_SRC(NUM_SRC), .ERR_W(ERR_W)) u_merge (
    .codes_i  (src_err_i),
    .merged_o (merged),
    .any_o    (any_err)
  );

  ehc_decide u_decide (
    .busy_i     (busy_o),
    .insn_end_i (insn_end_i),
    .stall_i    (stall_i),
    .any_err_i  (any_err),
    .halt_req_i (halt_req_i),
    .outcome_o  (outcome),
    .stop_o     (stop)
  );

  ehc_status #(.ERR_W(ERR_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .start_i    (start_i),
    .stop_i     (stop),
    .merged_i   (merged),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_bits_o (err_bits_o)
  );

  assign commit_o = (outcome == OUT_COMMIT);
  assign abort_o  = (outcome == OUT_ABORT);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !(commit_o && abort_o)); // R3

  AST_NO_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !busy_o |-> !(commit_o || abort_o)); // R7

  AST_ABORT_HALTS: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    abort_o |=> (done_o && !busy_o)); // R5

  AST_ABORT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    abort_o |=> (err_bits_o != '0)); // R1

  AST_ERRBITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!busy_o && !start_i) |=> $stable(err_bits_o)); // R9

  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    stall_i |-> !(commit_o || abort_o)); // R4
endmodule

// File: tb/err_halt_ctrl_test.sv
module err_halt_ctrl_test;
  localparam int NUM_SRC = 4;
  localparam int ERR_W   = 8;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     start_i = 1'b0;
  logic                     insn_end_i = 1'b0;
  logic                     stall_i = 1'b0;
  logic                     halt_req_i = 1'b0;
  logic [NUM_SRC*ERR_W-1:0] src_err_i = '0;
  logic                     commit_o, abort_o, done_o, busy_o;
  logic [ERR_W-1:0]         err_bits_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  err_halt_ctrl #(.NUM_SRC(NUM_SRC), .ERR_W(ERR_W)) uut (
    .clk_i, .rst_ni, .start_i, .insn_end_i, .stall_i, .halt_req_i,
    .src_err_i, .commit_o, .abort_o, .err_bits_o, .done_o, .busy_o
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // Drive one end-of-instruction cycle; return strobes sampled mid-cycle.
  task automatic retire(input logic [NUM_SRC*ERR_W-1:0] codes, input logic halt,
                        input logic stall, output logic c, output logic a);
    @(negedge clk_i);
    insn_end_i = 1'b1;
    halt_req_i = halt;
    stall_i    = stall;
    src_err_i  = codes;
    #1;
    c = commit_o;
    a = abort_o;
    @(negedge clk_i);
    insn_end_i = 1'b0;
    halt_req_i = 1'b0;
    stall_i    = 1'b0;
    src_err_i  = '0;
  endtask

  task automatic t_reset();
    check("R10", "busy", busy_o, 0);
    check("R10", "done", done_o, 0);
    check("R10", "err_bits", err_bits_o, 0);
    check("R10", "strobes", {commit_o, abort_o}, 0);
  endtask

  task automatic t_clean_commit();
    logic c, a;
    do_start();
    check("R9", "busy after start", busy_o, 1);
    retire('0, 1'b0, 1'b0, c, a);
    check("R2", "commit", c, 1);
    check("R3", "abort with commit", a, 0);
    check("R2", "still busy", busy_o, 1);
    #1;
    check("R3", "strobe one cycle", commit_o, 0);
  endtask

  task automatic t_stall();
    logic c, a;
    retire({8'h00, 8'h04, 8'h00, 8'h01}, 1'b1, 1'b1, c, a);
    check("R4", "no strobe in stall", {c, a}, 0);
    check("R4", "busy kept", busy_o, 1);
    check("R4", "done kept", done_o, 0);
    check("R4", "err_bits kept", err_bits_o, 0);
  endtask

  task automatic t_multi_err();
    logic c, a;
    // source0=01, source1=02, source3=10 (source2 silent)
    retire({8'h10, 8'h00, 8'h02, 8'h01}, 1'b0, 1'b0, c, a);
    check("R2", "abort", a, 1);
    check("R3", "no commit", c, 0);
    check("R1", "merged bits", err_bits_o, 8'h13);
    check("R5", "done", done_o, 1);
    check("R5", "busy", busy_o, 0);
  endtask

  task automatic t_halted_ignore();
    logic c, a;
    retire({8'h20, 8'h20, 8'h20, 8'h20}, 1'b0, 1'b0, c, a);
    check("R7", "no strobe when halted", {c, a}, 0);
    check("R7", "err_bits unchanged", err_bits_o, 8'h13);
    check("R9", "err_bits held", err_bits_o, 8'h13);
  endtask

  task automatic t_all_src_fatal();
    logic c, a;
    do_start();
    check("R9", "cleared on start", err_bits_o, 0);
    check("R9", "done cleared", done_o, 0);
    retire({8'h80, 8'h06, 8'h03, 8'h08}, 1'b0, 1'b0, c, a);
    check("R1", "all four merged", err_bits_o, 8'h8F);
    check("R8", "fatal bit 7", err_bits_o[7], 1);
  endtask

  task automatic t_end_program();
    logic c, a;
    do_start();
    retire('0, 1'b0, 1'b0, c, a);
    retire('0, 1'b1, 1'b0, c, a);
    check("R6", "halt commits", {c, a}, 2'b10);
    check("R6", "err_bits zero", err_bits_o, 0);
    check("R6", "done", done_o, 1);
    check("R6", "busy", busy_o, 0);
  endtask

  task automatic t_halt_with_err();
    logic c, a;
    do_start();
    retire({8'h00, 8'h40, 8'h00, 8'h00}, 1'b1, 1'b0, c, a);
    check("R6", "halt with error aborts", {c, a}, 2'b01);
    check("R6", "error reported", err_bits_o, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_clean_commit();
    t_stall();
    t_multi_err();
    t_halted_ignore();
    t_all_src_fatal();
    t_end_program();
    t_halt_with_err();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule